// File: doc/BRIEF.md
# Multi-Mode Register Shifter

This block shifts the contents of one 16-bit register, or of a pair of registers joined into a 32-bit doubleword, in a single step. A 4-bit operation code chooses the direction, the width and how the vacated bit positions are filled. There are four fill modes: zeros, ones, a copy of the edge bit, or the bits that leave at the other end (circular). The caller presents the register contents, the register index and a shift count, and pulses a start strobe. One clock later the block returns the new register values, the indices they belong to and a write enable for each.

A doubleword is formed from the register at the given index (high half) and the register after it (low half). The index of the low half wraps from the last register back to register 0. The count may equal the full width of the operand. A zero-fill shift of a single register by its full width clears the register, and a clear operation is issued as exactly this shift. A count of zero, or a count above the operand width, raises an error. In that case no write enable is raised and the returned words equal the inputs, so the registers keep their values.

Top module: `reg_shifter`

## Requirements
- R1: The operation code is decoded as follows. Bit 3 selects the direction (1 = left, 0 = right). Bit 2 selects the width (1 = doubleword, 0 = single register). Bits 1:0 select the fill mode: 00 zero, 01 one, 10 edge-bit extend, 11 circular.
- R2: A single-register right shift moves `hi_word` toward bit 0. The vacated high bits are filled with 0, with 1, or with copies of the original bit 15, or, in circular mode, with the bits shifted out. `res_lo` returns `lo_word` and `wr_lo` stays 0.
- R3: A single-register left shift moves `hi_word` toward bit 15. The vacated low bits are filled with 0, with 1, or with copies of the original bit 0, or, in circular mode, with the bits shifted out.
- R4: A doubleword shift treats {`hi_word`,`lo_word`} as one 32-bit value with `hi_word` as the upper half. It applies the same direction and fill rules across 32 bits and returns the halves on `res_hi`/`res_lo`, with both `wr_hi` and `wr_lo` set.
- R5: The legal count range is 1..16 for a single register and 1..32 for a doubleword. Any other count sets `err`, clears both write enables and returns `res_hi`=`hi_word` and `res_lo`=`lo_word`.
- R6: A count equal to the operand width is legal. Zero fill gives all zeros, one fill gives all ones, extend gives copies of the edge bit, and circular returns the operand unchanged.
- R7: `hi_idx` returns `reg_idx` and `lo_idx` returns the next register index, which wraps from 15 to 0.
- R8: `done` is high exactly in the cycle after a cycle in which `start` was sampled high. Results, indices and flags appear with it. `res_hi`, `res_lo`, `hi_idx` and `lo_idx` hold their values until the next start.
- R9: While `rst_n` is low at a clock edge, `done`, `err`, `wr_hi` and `wr_lo` go to 0 and both result words go to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation with the present inputs |
| op | input | 4 | Operation code: direction, width, fill mode |
| count | input | 6 | Number of bit positions to shift |
| reg_idx | input | 4 | Index of the (high) register operated on |
| hi_word | input | 16 | Contents of register `reg_idx` |
| lo_word | input | 16 | Contents of the next register (used for doubleword) |
| done | output | 1 | Result valid, one cycle after start |
| err | output | 1 | Count out of range; no write |
| wr_hi | output | 1 | Write `res_hi` to register `hi_idx` |
| wr_lo | output | 1 | Write `res_lo` to register `lo_idx` |
| hi_idx | output | 4 | Register index for `res_hi` |
| lo_idx | output | 4 | Register index for `res_lo`, wrapped |
| res_hi | output | 16 | New high (or single) register value |
| res_lo | output | 16 | New low register value |

## Verification
Every result, index and flag is registered once, so it is due exactly one clock edge after the edge that sampled `start`. The bench drives its inputs on a falling edge, lets one rising edge pass and compares all outputs on the next falling edge, clear of both edges. Idle cycles placed at intervals confirm that `done` falls back one edge after `start` drops while the results hold. The sweep covers all sixteen operation codes and every count from 0 to 40, which includes both full-width limits and the first illegal count of each width.

// File: rtl/reg_shifter_pkg.sv
// Shared types for the register shifter: fill-mode encoding and the
// decoded layout of the 4-bit operation code.
package reg_shifter_pkg;

    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_ONE  = 2'b01,
        FILL_EXT  = 2'b10,
        FILL_ROT  = 2'b11
    } fill_e;

    typedef struct packed {
        logic  left;   // 1 = toward the most significant bit
        logic  dbl;    // 1 = register pair as one doubleword
        fill_e fill;   // source of the vacated bits
    } shift_op_t;

endpackage

// File: rtl/shift_core.sv
// Combinational shifter for one operand width.
// Shifts din by amount in either direction, filling with zeros, ones,
// the edge bit (msb going right, lsb going left) or rotating.
// Assumes amount <= WIDTH whenever the output is used; larger amounts
// give a defined but meaningless value that the caller discards.
module shift_core
    import reg_shifter_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int CNT_W = 6
) (
    input  logic             left,
    input  fill_e            fill,
    input  logic [CNT_W-1:0] amount,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic             edge_bit;
    logic [WIDTH-1:0] ext;
    logic [2*WIDTH-1:0] wide;

    // Pick the word that supplies bits shifted in from outside.
    always_comb begin
        unique case (fill)
            FILL_ZERO: edge_bit = 1'b0;
            FILL_ONE:  edge_bit = 1'b1;
            FILL_EXT:  edge_bit = left ? din[0] : din[WIDTH-1];
            default:   edge_bit = 1'b0;
        endcase
        ext = (fill == FILL_ROT) ? din : {WIDTH{edge_bit}};
    end

    // Shift the fill word and the operand as one double-width value.
    always_comb begin
        if (left) begin
            wide = {din, ext} << amount;
            dout = wide[2*WIDTH-1:WIDTH];
        end else begin
            wide = {ext, din} >> amount;
            dout = wide[WIDTH-1:0];
        end
    end

endmodule

// File: rtl/count_check.sv
// Range check of the shift count: legal counts are 1..WORD_W for a
// single register and 1..2*WORD_W for a doubleword.
// Assumes CNT_W can hold 2*WORD_W.
module count_check #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic             dbl,
    input  logic [CNT_W-1:0] amount,
    output logic             bad
);

    localparam logic [CNT_W-1:0] LIM_SINGLE = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] LIM_DOUBLE = CNT_W'(2 * WORD_W);

    logic [CNT_W-1:0] limit;

    // Flag a zero count or one beyond the operand width.
    always_comb begin
        limit = dbl ? LIM_DOUBLE : LIM_SINGLE;
        bad   = (amount == '0) || (amount > limit);
    end

endmodule

// File: rtl/reg_shifter.sv
// Multi-mode register shifter, top level.
// Computes single-register and doubleword shifts in parallel, selects
// by the operation code, range-checks the count and registers the
// results, write enables and target indices one cycle after start.
// Assumes hi_word holds register reg_idx and lo_word the next one.
module reg_shifter
    import reg_shifter_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int NREG   = 16,
    localparam int CNT_W = $clog2(2 * WORD_W + 1),
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [CNT_W-1:0]  count,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [WORD_W-1:0] hi_word,
    input  logic [WORD_W-1:0] lo_word,
    output logic              done,
    output logic              err,
    output logic              wr_hi,
    output logic              wr_lo,
    output logic [IDX_W-1:0]  hi_idx,
    output logic [IDX_W-1:0]  lo_idx,
    output logic [WORD_W-1:0] res_hi,
    output logic [WORD_W-1:0] res_lo
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG - 1);

    shift_op_t           op_s;
    logic [WORD_W-1:0]   single_out;
    logic [2*WORD_W-1:0] double_out;
    logic [WORD_W-1:0]   nxt_hi;
    logic [WORD_W-1:0]   nxt_lo;
    logic [IDX_W-1:0]    nxt_idx;
    logic                bad;

    assign op_s = shift_op_t'(op);

    shift_core #(.WIDTH(WORD_W), .CNT_W(CNT_W)) u_single (
        .left   (op_s.left),
        .fill   (op_s.fill),
        .amount (count),
        .din    (hi_word),
        .dout   (single_out)
    );

    shift_core #(.WIDTH(2 * WORD_W), .CNT_W(CNT_W)) u_double (
        .left   (op_s.left),
        .fill   (op_s.fill),
        .amount (count),
        .din    ({hi_word, lo_word}),
        .dout   (double_out)
    );

    count_check #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_range (
        .dbl    (op_s.dbl),
        .amount (count),
        .bad    (bad)
    );

    // Choose the result words; an illegal count keeps the inputs.
    always_comb begin
        if (bad) begin
            nxt_hi = hi_word;
            nxt_lo = lo_word;
        end else if (op_s.dbl) begin
            nxt_hi = double_out[2*WORD_W-1:WORD_W];
            nxt_lo = double_out[WORD_W-1:0];
        end else begin
            nxt_hi = single_out;
            nxt_lo = lo_word;
        end
    end

    // Index of the low half, wrapping past the last register.
    always_comb begin
        nxt_idx = (reg_idx == LAST_IDX) ? '0 : reg_idx + 1'b1;
    end

    // Strobe-type outputs: valid for the one cycle after start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            err   <= 1'b0;
            wr_hi <= 1'b0;
            wr_lo <= 1'b0;
        end else begin
            done  <= start;
            err   <= start & bad;
            wr_hi <= start & ~bad;
            wr_lo <= start & ~bad & op_s.dbl;
        end
    end

    // Data outputs: captured on start and held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi <= '0;
            res_lo <= '0;
            hi_idx <= '0;
            lo_idx <= '0;
        end else if (start) begin
            res_hi <= nxt_hi;
            res_lo <= nxt_lo;
            hi_idx <= reg_idx;
            lo_idx <= nxt_idx;
        end
    end

endmodule

// File: rtl/reg_shifter_chk.sv
// Protocol and result checks for reg_shifter, attached by bind.
// Observes the ports only.
module reg_shifter_chk #(
    parameter int WORD_W = 16,
    parameter int NREG   = 16,
    localparam int CNT_W = $clog2(2 * WORD_W + 1),
    localparam int IDX_W = $clog2(NREG)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [3:0]        op,
    input logic [CNT_W-1:0]  count,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [WORD_W-1:0] hi_word,
    input logic [WORD_W-1:0] lo_word,
    input logic              done,
    input logic              err,
    input logic              wr_hi,
    input logic              wr_lo,
    input logic [IDX_W-1:0]  hi_idx,
    input logic [IDX_W-1:0]  lo_idx,
    input logic [WORD_W-1:0] res_hi,
    input logic [WORD_W-1:0] res_lo
);

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R8
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R8
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(res_hi) && $stable(res_lo)); // R8
    AST_ERR_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) err |-> !wr_hi && !wr_lo); // R5
    AST_ZERO_COUNT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) start && count == '0 |=> err && res_hi == $past(hi_word) && res_lo == $past(lo_word)); // R5
    AST_LO_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n) wr_lo |-> wr_hi); // R4
    AST_SINGLE_NO_LO: assert property (@(posedge clk) disable iff (!rst_n) start && !op[2] |=> !wr_lo); // R2
    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n) done && hi_idx == IDX_W'(NREG - 1) |-> lo_idx == '0); // R7
    AST_FULL_ROTATE_SAME: assert property (@(posedge clk) disable iff (!rst_n) start && op == 4'b0011 && count == CNT_W'(WORD_W) |=> res_hi == $past(hi_word)); // R6

endmodule

bind reg_shifter reg_shifter_chk #(.WORD_W(WORD_W), .NREG(NREG)) u_chk (.*);

// File: tb/test_reg_shifter.sv
// Sweep bench: every operation code against counts 0..40 and several
// data patterns, expected values built bit by bit from the rules.
module test_reg_shifter;

    localparam int W  = 16;
    localparam int CW = 6;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    op = '0;
    logic [CW-1:0] count = '0;
    logic [IW-1:0] reg_idx = '0;
    logic [W-1:0]  hi_word = '0;
    logic [W-1:0]  lo_word = '0;
    logic          done, err, wr_hi, wr_lo;
    logic [IW-1:0] hi_idx, lo_idx;
    logic [W-1:0]  res_hi, res_lo;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    reg_shifter i_reg_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .count(count),
        .reg_idx(reg_idx), .hi_word(hi_word), .lo_word(lo_word),
        .done(done), .err(err), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .hi_idx(hi_idx), .lo_idx(lo_idx), .res_hi(res_hi), .res_lo(res_lo)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    // Bitwise reference: out[i] takes source bit i+n (right) or i-n (left).
    function automatic logic [31:0] model(input bit left, input int w, input logic [1:0] fill,
                                          input int n, input logic [31:0] x);
        logic [31:0] y = '0;
        for (int i = 0; i < w; i++) begin
            int src = left ? i - n : i + n;
            if (src >= 0 && src < w) y[i] = x[src];
            else if (fill == 2'b11) y[i] = x[((src % w) + w) % w];
            else if (fill == 2'b00) y[i] = 1'b0;
            else if (fill == 2'b01) y[i] = 1'b1;
            else y[i] = left ? x[0] : x[w-1];
        end
        return y;
    endfunction

    function automatic logic [31:0] pattern(input int p);
        case (p)
            0: return 32'hA5C3_0F1E;
            1: return 32'h8001_7FFE;
            2: return 32'h4000_0002;
            3: return 32'hFFFF_0000;
            4: return 32'h1234_FEDC;
            default: return 32'h0001_8000;
        endcase
    endfunction

    // Drive one operation, wait one rising edge, compare on the falling edge.
    task automatic apply(input logic [3:0] o, input int n, input int idx, input logic [31:0] d);
        bit left = o[3];
        bit dbl = o[2];
        int w = dbl ? 2 * W : W;
        bit bad = (n == 0) || (n > w);
        logic [31:0] y;
        logic [W-1:0] eh, el;
        logic [3:0] flags;
        string tag;
        op = o; count = CW'(n); reg_idx = IW'(idx);
        hi_word = d[31:16]; lo_word = d[15:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (bad) begin
            eh = d[31:16]; el = d[15:0];
            flags = 4'b1100;
            tag = "R5 bad count";
        end else if (dbl) begin
            y = model(left, 2 * W, o[1:0], n, d);
            eh = y[31:16]; el = y[15:0];
            flags = 4'b1011;
            tag = (n == w) ? "R6 full doubleword" : "R4 doubleword";
        end else begin
            y = model(left, W, o[1:0], n, {16'h0, d[31:16]});
            eh = y[15:0]; el = d[15:0];
            flags = 4'b1010;
            tag = (n == w) ? "R6 full single" : (left ? "R3 single left" : "R2 single right");
        end
        chk($sformatf("%s op=%h n=%0d data", tag, o, n), {32'h0, res_hi, res_lo}, {32'h0, eh, el});
        chk($sformatf("R1/R8 op=%h n=%0d flags", o, n), {60'h0, done, err, wr_hi, wr_lo}, {60'h0, flags});
        chk($sformatf("R7 idx=%0d", idx), {56'h0, hi_idx, lo_idx}, {56'h0, IW'(idx), IW'((idx + 1) % 16)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [W-1:0] hold_hi, hold_lo;
        int v = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset", {58'h0, done, err, wr_hi, wr_lo, 2'b00}, 64'h0);
        chk("R9 reset words", {32'h0, res_hi, res_lo}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n <= 40; n++) begin
                for (int p = 0; p < 3; p++) begin
                    apply(4'(o), n, (o + n + p) % 16, pattern((o * 41 + n + p) % 6));
                    v++;
                    if (v % 37 == 0) begin
                        hold_hi = res_hi; hold_lo = res_lo;
                        @(negedge clk);
                        // R8: done drops, results hold with start low
                        chk("R8 idle done", {63'h0, done}, 64'h0);
                        chk("R8 idle hold", {32'h0, res_hi, res_lo}, {32'h0, hold_hi, hold_lo});
                    end
                end
            end
        end
        // R6: clear of an all-ones register by a full zero-fill shift
        apply(4'b0000, 16, 15, 32'hFFFF_FFFF);
        chk("R6 clear", {48'h0, res_hi}, 64'h0);
        // R7: wrap of the low index from the last register
        chk("R7 wrap", {60'h0, lo_idx}, 64'h0);
        finished = 1'b1;
        summary();
    end

endmodule